// File: doc/BRIEF.md
# Single-Channel Block-Write DMA Engine

This engine copies a block of words from a streaming source device into system memory without the processor handling each word. Software loads a start address and a word count through a four-entry register port, then writes the start bit. The engine raises a bus request and waits for the processor's grant. It drives memory write cycles only while the grant is high. Each word is taken from the device with a valid/ready handshake.

The device presents a word with `dev_valid` and must hold `dev_data` steady until the engine answers with `dev_ready`. `dev_ready` is high only in a cycle where the grant is present. In that same cycle the word is written to memory. Withdrawing the grant, or leaving `dev_valid` low, stalls the transfer without losing data. The request stays high for the whole block. When the last word has been written, the engine releases the bus, sets a done flag and pulses an interrupt.

Top module: `dma_block_mover`

## Requirements
- R1: After reset, `bus_req`, `irq` and `mem_we` are 0, and the address, count and status registers read 0.
- R2: `mem_we`, `mem_addr` and `mem_wdata` are all 0 in any cycle where `bus_gnt` is low, and a write happens only while both `bus_req` and `bus_gnt` are high.
- R3: A start write (select 2, bit 0 set) with a nonzero count raises `bus_req` in the cycle after the write edge. `bus_req` stays high until the last word has been written.
- R4: Each word is written at the current address register value. After each write the address register reads one higher and the count register (select 1) reads one lower; the address register is select 0.
- R5: A word moves only in a cycle with `dev_valid` and `bus_gnt` both high. `dev_ready` is high in exactly those cycles, and `mem_wdata` equals `dev_data` there.
- R6: In the cycle after the last write edge, `bus_req` is 0 and `irq` is 1 for that one cycle. The status register (select 3) then reads busy bit 0 = 0 and done bit 1 = 1.
- R7: A start write while a transfer is busy is ignored. The busy bit stays 1 and `bus_req` stays high.
- R8: A start write with count 0 sets done and pulses `irq` in the next cycle, and `bus_req` is never raised.
- R9: Writes to the address or count register while busy are ignored.
- R10: An accepted start write clears the done bit, so the status reads 1 (busy only) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Combinational read of the selected register |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| dev_valid | input | 1 | Device has a word ready |
| dev_data | input | DATA_W | Device word |
| dev_ready | output | 1 | Word accepted this cycle |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
`bus_req` and the busy and done bits change one edge after the start write. The bench therefore samples them at the next falling edge. A word's memory write, `dev_ready` and `mem_wdata` appear combinationally in the handshake cycle. The address and count advance one edge later, and `irq` follows one edge after the final write. A falling-edge monitor pops the expected address/data pair on each write and then checks `irq` exactly one cycle later. Register reads are taken at mid-low phase, away from every edge.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } xfer_state_e;

  localparam int CTRL_START_BIT  = 0;
  localparam int STAT_BUSY_BIT   = 0;
  localparam int STAT_DONE_BIT   = 1;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              count_zero,
  output logic              count_one
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic sw_load_ok;
  assign sw_load_ok = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
    end else if (beat) begin
      addr_q  <= addr_q + ADDR_W'(1);
      count_q <= count_q - CNT_ONE;
    end else if (sw_load_ok) begin
      if (sel == SEL_ADDR)  addr_q  <= wdata;
      if (sel == SEL_COUNT) count_q <= wdata[CNT_W-1:0];
    end
  end

  assign count_zero = (count_q == '0);
  assign count_one  = (count_q == CNT_ONE);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> count_q == $past(count_q) - CNT_ONE); // R4
  AST_BUSY_LOCKS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> $stable(addr_q) && $stable(count_q)); // R9
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic count_zero,
  input  logic count_one,
  input  logic beat,
  output logic busy,
  output logic done,
  output logic irq
);
  xfer_state_e state_q;
  logic        finish;

  assign busy   = (state_q == ST_MOVE);
  assign finish = busy && beat && count_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            if (count_zero) begin
              done <= 1'b1;
              irq  <= 1'b1;
            end else begin
              done    <= 1'b0;
              state_q <= ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (finish) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            irq     <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_HOLD_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(beat && count_one)) |=> busy); // R3
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !beat) |=> busy && !done); // R7
  AST_ZERO_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req && count_zero) |=> !busy && done && irq); // R8
endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              busy,
  input  logic              bus_gnt,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              bus_req,
  output logic              beat,
  output logic              dev_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic own_bus;

  assign bus_req   = busy;
  assign own_bus   = busy && bus_gnt;
  assign beat      = own_bus && dev_valid;
  assign dev_ready = beat;
  assign mem_we    = beat;
  assign mem_addr  = own_bus ? addr_q : '0;
  assign mem_wdata = beat ? dev_data : '0;
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  output logic              irq
);
  reg_sel_e          sel;
  logic              start_req;
  logic              busy, done, beat;
  logic              count_zero, count_one;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q;
  logic [1:0]        status_bits;

  assign sel       = reg_sel_e'(reg_sel);
  assign start_req = reg_wr && (sel == SEL_CTRL) && reg_wdata[CTRL_START_BIT];

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
    .busy(busy), .beat(beat), .addr_q(addr_q), .count_q(count_q),
    .count_zero(count_zero), .count_one(count_one)
  );

  dma_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .count_zero(count_zero),
    .count_one(count_one), .beat(beat), .busy(busy), .done(done), .irq(irq)
  );

  dma_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .busy(busy), .bus_gnt(bus_gnt), .dev_valid(dev_valid), .dev_data(dev_data),
    .addr_q(addr_q), .bus_req(bus_req), .beat(beat), .dev_ready(dev_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_comb begin
    status_bits                = '0;
    status_bits[STAT_BUSY_BIT] = busy;
    status_bits[STAT_DONE_BIT] = done;
    case (sel)
      SEL_ADDR:   reg_rdata = addr_q;
      SEL_COUNT:  reg_rdata = ADDR_W'(count_q);
      SEL_STATUS: reg_rdata = ADDR_W'(status_bits);
      default:    reg_rdata = '0;
    endcase
  end

  AST_WRITE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_gnt && bus_req)); // R2
  AST_QUIET_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (!mem_we && mem_addr == '0 && mem_wdata == '0)); // R2
  AST_ACK_MATCHES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> (mem_we && dev_valid && mem_wdata == dev_data)); // R5
  AST_REQ_DROPS_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> irq); // R6
endmodule

// File: tb/dma_block_mover_tb_top.sv
`timescale 1ns/1ps
module dma_block_mover_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd3;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          dev_valid = 1'b0;
  logic [DW-1:0] dev_data = '0;
  logic          dev_ready;
  logic          irq;

  int   n_checks = 0;
  int   n_fails  = 0;
  logic gnt_enable = 1'b1;
  logic dev_en = 1'b1;
  logic irq_due = 1'b0;
  logic prev_irq = 1'b0;
  logic req_seen = 1'b0;
  logic [DW-1:0] mem_model [256];
  logic [DW-1:0]           src_q[$];
  logic [AW+DW-1:0]        exp_q[$];

  always #2.5 clk = ~clk;

  dma_block_mover #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .dev_valid(dev_valid), .dev_data(dev_data),
    .dev_ready(dev_ready), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // processor grant model, memory model and device model
  always @(posedge clk) begin
    bus_gnt <= bus_req && gnt_enable;
    if (mem_we) mem_model[mem_addr[7:0]] <= mem_wdata;
    if (dev_valid && dev_ready) void'(src_q.pop_front());
    dev_valid <= dev_en && (src_q.size() > 0);
    dev_data  <= (src_q.size() > 0) ? src_q[0] : '0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req) req_seen = 1'b1;
      if (irq_due) begin
        check(irq && !bus_req, "R6 irq/release after last write", {irq, bus_req}, 2'b10);
        irq_due = 1'b0;
      end else if (irq && prev_irq) begin
        check(1'b0, "R6 irq wider than one cycle", 1, 0);
      end
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected write", mem_addr, 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R4 write addr/data", {mem_addr, mem_wdata}, e);
          check(dev_ready && dev_valid && bus_gnt, "R5 ack with write",
                {dev_ready, dev_valid, bus_gnt}, 3'b111);
          if (exp_q.size() == 0) irq_due = 1'b1;
        end
      end
      if (dev_valid && !bus_gnt)
        check(!dev_ready && !mem_we && mem_addr == '0, "R2 idle bus without grant",
              {dev_ready, mem_we, mem_addr}, 0);
      prev_irq = irq;
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [AW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [AW-1:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic load_block(input logic [AW-1:0] a, input int n, input logic [DW-1:0] seed);
    reg_write(2'd0, a);
    reg_write(2'd1, AW'(n));
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w;
      w = seed + DW'(i * 37);
      exp_q.push_back({a + AW'(i), w});
      src_q.push_back(w);
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic finish_checks(input logic [AW-1:0] a, input int n, input logic [DW-1:0] seed);
    logic [AW-1:0] v;
    wait_irq();
    check(irq == 1'b1, "R6 irq seen", irq, 1);
    reg_read(2'd3, v);
    check(v == 2, "R6 status done", v, 2);
    reg_read(2'd0, v);
    check(v == a + AW'(n), "R4 final address", v, a + AW'(n));
    reg_read(2'd1, v);
    check(v == 0, "R4 final count", v, 0);
    for (int i = 0; i < n; i++)
      check(mem_model[8'(a + AW'(i))] == seed + DW'(i * 37), "R4 memory contents",
            mem_model[8'(a + AW'(i))], seed + DW'(i * 37));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : stimulus
    logic [AW-1:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check({bus_req, irq, mem_we} == 0, "R1 outputs after reset", {bus_req, irq, mem_we}, 0);
    reg_read(2'd3, v); check(v == 0, "R1 status after reset", v, 0);
    reg_read(2'd0, v); check(v == 0, "R1 address after reset", v, 0);
    reg_read(2'd1, v); check(v == 0, "R1 count after reset", v, 0);

    // block with free grant and steady device
    load_block(16'h0010, 4, 16'h1200);
    reg_write(2'd2, 16'h0001);
    @(negedge clk);
    check(bus_req == 1'b1, "R3 request after start", bus_req, 1);
    check(reg_rdata == 1, "R10 status busy only", reg_rdata, 1);
    finish_checks(16'h0010, 4, 16'h1200);

    // block with gaps in grant and device valid
    load_block(16'h0040, 5, 16'h5a00);
    reg_write(2'd2, 16'h0001);
    @(negedge clk);
    check(reg_rdata == 1, "R10 done cleared by start", reg_rdata, 1);
    fork
      finish_checks(16'h0040, 5, 16'h5a00);
      begin
        repeat (2) @(posedge clk);
        #1 dev_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 dev_en = 1'b1; gnt_enable = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(bus_req == 1'b1, "R3 request held during stall", bus_req, 1);
        #1 gnt_enable = 1'b1;
      end
    join

    // zero count completes immediately
    req_seen = 1'b0;
    reg_write(2'd1, 16'h0000);
    reg_write(2'd2, 16'h0001);
    @(negedge clk);
    check(irq == 1'b1 && bus_req == 1'b0, "R8 zero count irq", {irq, bus_req}, 2'b10);
    check(reg_rdata == 2, "R8 zero count status", reg_rdata, 2);
    repeat (4) @(negedge clk);
    check(req_seen == 1'b0, "R8 request never raised", req_seen, 0);

    // restart and register writes while busy
    gnt_enable = 1'b0;
    load_block(16'h0080, 3, 16'h0c00);
    reg_write(2'd2, 16'h0001);
    reg_write(2'd2, 16'h0001);
    @(negedge clk);
    check(reg_rdata == 1 && bus_req, "R7 start while busy ignored", reg_rdata, 1);
    reg_write(2'd0, 16'h00aa);
    reg_read(2'd0, v); check(v == 16'h0080, "R9 address locked while busy", v, 16'h0080);
    reg_write(2'd1, 16'h0009);
    reg_read(2'd1, v); check(v == 3, "R9 count locked while busy", v, 3);
    gnt_enable = 1'b1;
    finish_checks(16'h0080, 3, 16'h0c00);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule